// File: doc/BRIEF.md
# Legacy Keyboard/Mouse Controller Host Command Decoder

This block is the host-side register front end of a legacy keyboard and mouse controller. The host sees two byte-wide ports. A byte written to the command port is decoded as a controller command. A byte written to the data port either finishes a two-phase command that an earlier command byte armed, or goes straight to the keyboard device when nothing is armed. The block holds the controller mode byte, the status byte and the output port, and drives the A20 gate and a system reset request from them.

Single-byte replies go to an output-buffer arbiter outside this block, as a one-cycle strobe with a flag that marks a reply posed as mouse data. Raw bytes for the keyboard or the mouse leave through one shared byte bus, with a separate strobe for each side. The serial line protocol, the device queues and the interrupt lines are handled elsewhere. The interrupt logic gets a one-cycle mode-update strobe so that it can re-evaluate its lines. Every output is registered, so each effect of a write shows up in the cycle after the clock edge that samples it.

Top module: `kbc_host_decoder`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output port is 0xCF and the A20 gate is high. No command is armed, so the first data-port write goes to the keyboard.
- R2: A data-port write with no armed command raises kbd_tx_valid for one cycle, with the written byte on tx_byte.
- R3: Command bytes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a two-phase command. The next data-port write is consumed by that command and disarms it, so the data write after that goes to the keyboard again.
- R4: Data following 0x60 replaces the mode byte, and mode_upd pulses for one cycle.
- R5: 0x20 replies with the mode byte and 0xD0 replies with the output port. 0xC0 replies with 0x80, and 0xA9 and 0xAB reply with 0x00. Each reply is one reply_valid cycle with reply_aux low.
- R6: 0xAA sets status bit 2 and replies with 0x55.
- R7: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. No other mode bit changes.
- R8: 0xDD clears output-port bit 1 and lowers the A20 gate. 0xDF sets that bit and raises the gate.
- R9: Any command 0xF0 to 0xFF with bit 0 low pulses sys_reset_req for one cycle. With bit 0 high the command has no effect.
- R10: Data following 0xD1 replaces the output port, and the A20 gate follows the new bit 1. When the new bit 0 is 0, sys_reset_req pulses for one cycle.
- R11: Data following 0xD2 comes back as a reply with reply_aux low. Data following 0xD3 comes back as a reply with reply_aux high.
- R12: Data following 0xD4 raises aux_tx_valid for one cycle, with the byte on tx_byte.
- R13: An unrecognised command byte changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command-port write strobe; takes precedence over data_wr |
| data_wr | input | 1 | Data-port write strobe |
| wr_byte | input | 8 | Byte written by the host |
| status_byte | output | 8 | Status byte, readable at any time |
| mode_byte | output | 8 | Controller mode byte |
| outport_byte | output | 8 | Output port value |
| a20_gate | output | 1 | A20 gate level (output-port bit 1) |
| sys_reset_req | output | 1 | One-cycle system reset request |
| mode_upd | output | 1 | One-cycle strobe after a mode-byte write |
| reply_valid | output | 1 | One-cycle strobe: reply byte for the output-buffer arbiter |
| reply_aux | output | 1 | Reply is to be posed as mouse data |
| reply_byte | output | 8 | Reply byte |
| kbd_tx_valid | output | 1 | One-cycle strobe: tx_byte goes to the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe: tx_byte goes to the mouse |
| tx_byte | output | 8 | Byte forwarded to a device |

## Verification
The assertions check on every cycle that at most one byte strobe fires at a time and that a data write always disarms the pending command. They also check that the A20 gate and the reset request move only in the cycle after a host write, that status bit 2 rises only after the self-test command, and that a mode write lands with its update strobe. The bench scenarios are needed to show the values themselves: each canned reply byte, the folding of the whole 0xF0 to 0xFF range by bit 0, the bit-0 reset cause of an output-port write, the routing of each two-phase command, and that unknown commands leave every register alone.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RD_MODE   = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_WR_MODE   = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_AUX_OFF   = 8'hA7;
  localparam logic [BYTE_W-1:0] CMD_AUX_ON    = 8'hA8;
  localparam logic [BYTE_W-1:0] CMD_AUX_TEST  = 8'hA9;
  localparam logic [BYTE_W-1:0] CMD_SELFTEST  = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_KBD_TEST  = 8'hAB;
  localparam logic [BYTE_W-1:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [BYTE_W-1:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [BYTE_W-1:0] CMD_RD_INPORT = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_RD_OUTP   = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_WR_OUTP   = 8'hD1;
  localparam logic [BYTE_W-1:0] CMD_WR_KOBUF  = 8'hD2;
  localparam logic [BYTE_W-1:0] CMD_WR_AOBUF  = 8'hD3;
  localparam logic [BYTE_W-1:0] CMD_TO_AUX    = 8'hD4;
  localparam logic [BYTE_W-1:0] CMD_A20_LOW   = 8'hDD;
  localparam logic [BYTE_W-1:0] CMD_A20_HIGH  = 8'hDF;
  localparam logic [3:0]        PULSE_NIBBLE  = 4'hF;

  localparam int MODE_KBD_OFF_BIT = 4;
  localparam int MODE_AUX_OFF_BIT = 5;
  localparam int STAT_SELFTEST_BIT = 2;
  localparam int OUTP_RUN_BIT = 0;
  localparam int OUTP_A20_BIT = 1;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTP, PEND_KOBUF, PEND_AOBUF, PEND_AUX
  } pend_e;

  typedef enum logic [1:0] {RSRC_CONST, RSRC_MODE, RSRC_OUTP} rsrc_e;

  typedef struct packed {
    logic              arm_en;
    pend_e             arm_kind;
    logic              reply_en;
    rsrc_e             reply_src;
    logic [BYTE_W-1:0] reply_const;
    logic              selftest;
    logic [BYTE_W-1:0] mode_set;
    logic [BYTE_W-1:0] mode_clr;
    logic              a20_set;
    logic              a20_clr;
    logic              rst_pulse;
  } cmd_dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output cmd_dec_t          dec
);
  always_comb begin
    dec = '0;
    dec.arm_kind  = PEND_NONE;
    dec.reply_src = RSRC_CONST;
    if (cmd[BYTE_W-1 -: 4] == PULSE_NIBBLE) begin
      dec.rst_pulse = ~cmd[0];
    end else begin
      case (cmd)
        CMD_RD_MODE:   begin dec.reply_en = 1'b1; dec.reply_src = RSRC_MODE; end
        CMD_RD_OUTP:   begin dec.reply_en = 1'b1; dec.reply_src = RSRC_OUTP; end
        CMD_RD_INPORT: begin dec.reply_en = 1'b1; dec.reply_const = 8'h80; end
        CMD_AUX_TEST,
        CMD_KBD_TEST:  dec.reply_en = 1'b1;
        CMD_SELFTEST:  begin
          dec.reply_en    = 1'b1;
          dec.reply_const = 8'h55;
          dec.selftest    = 1'b1;
        end
        CMD_WR_MODE:   begin dec.arm_en = 1'b1; dec.arm_kind = PEND_MODE;  end
        CMD_WR_OUTP:   begin dec.arm_en = 1'b1; dec.arm_kind = PEND_OUTP;  end
        CMD_WR_KOBUF:  begin dec.arm_en = 1'b1; dec.arm_kind = PEND_KOBUF; end
        CMD_WR_AOBUF:  begin dec.arm_en = 1'b1; dec.arm_kind = PEND_AOBUF; end
        CMD_TO_AUX:    begin dec.arm_en = 1'b1; dec.arm_kind = PEND_AUX;   end
        CMD_AUX_OFF:   dec.mode_set[MODE_AUX_OFF_BIT] = 1'b1;
        CMD_AUX_ON:    dec.mode_clr[MODE_AUX_OFF_BIT] = 1'b1;
        CMD_KBD_OFF:   dec.mode_set[MODE_KBD_OFF_BIT] = 1'b1;
        CMD_KBD_ON:    dec.mode_clr[MODE_KBD_OFF_BIT] = 1'b1;
        CMD_A20_LOW:   dec.a20_clr = 1'b1;
        CMD_A20_HIGH:  dec.a20_set = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_pend_latch.sv
module kbc_pend_latch
  import kbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_wr,
  input  logic     data_wr,
  input  cmd_dec_t dec,
  output pend_e    pend
);
  pend_e pend_q, pend_d;
  logic  pend_en;

  always_comb begin
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (cmd_wr) begin
      if (dec.arm_en) begin
        pend_en = 1'b1;
        pend_d  = dec.arm_kind;
      end
    end else if (data_wr) begin
      pend_en = 1'b1;
      pend_d  = PEND_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= PEND_NONE;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R3
  disarm_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr) |=> (pend_q == PEND_NONE));
endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_INIT = 8'h03,
  parameter logic [BYTE_W-1:0] STAT_INIT = 8'h18,
  parameter logic [BYTE_W-1:0] OUTP_INIT = 8'hCF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  cmd_dec_t          dec,
  input  pend_e             pend,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] outp_q,
  output logic              rst_req_q,
  output logic              mupd_q,
  output logic              rep_v_q,
  output logic              rep_aux_q,
  output logic [BYTE_W-1:0] rep_b_q,
  output logic              ktx_v_q,
  output logic              atx_v_q,
  output logic [BYTE_W-1:0] tx_b_q
);
  logic [BYTE_W-1:0] mode_d, stat_d, outp_d, rep_b_d, tx_b_d;
  logic              rst_req_d, mupd_d, rep_v_d, rep_aux_d, ktx_v_d, atx_v_d;
  logic              state_en, rep_b_en, tx_b_en;

  always_comb begin
    mode_d    = mode_q;
    stat_d    = stat_q;
    outp_d    = outp_q;
    rep_b_d   = rep_b_q;
    tx_b_d    = tx_b_q;
    rst_req_d = 1'b0;
    mupd_d    = 1'b0;
    rep_v_d   = 1'b0;
    rep_aux_d = 1'b0;
    ktx_v_d   = 1'b0;
    atx_v_d   = 1'b0;
    if (cmd_wr) begin
      mode_d = (mode_q | dec.mode_set) & ~dec.mode_clr;
      if (dec.selftest) stat_d[STAT_SELFTEST_BIT] = 1'b1;
      if (dec.a20_set)  outp_d[OUTP_A20_BIT] = 1'b1;
      if (dec.a20_clr)  outp_d[OUTP_A20_BIT] = 1'b0;
      rst_req_d = dec.rst_pulse;
      if (dec.reply_en) begin
        rep_v_d = 1'b1;
        case (dec.reply_src)
          RSRC_MODE: rep_b_d = mode_q;
          RSRC_OUTP: rep_b_d = outp_q;
          default:   rep_b_d = dec.reply_const;
        endcase
      end
    end else if (data_wr) begin
      case (pend)
        PEND_MODE:  begin mode_d = wr_byte; mupd_d = 1'b1; end
        PEND_OUTP:  begin outp_d = wr_byte; rst_req_d = ~wr_byte[OUTP_RUN_BIT]; end
        PEND_KOBUF: begin rep_v_d = 1'b1; rep_b_d = wr_byte; end
        PEND_AOBUF: begin rep_v_d = 1'b1; rep_aux_d = 1'b1; rep_b_d = wr_byte; end
        PEND_AUX:   begin atx_v_d = 1'b1; tx_b_d = wr_byte; end
        default:    begin ktx_v_d = 1'b1; tx_b_d = wr_byte; end
      endcase
    end
  end

  assign state_en = cmd_wr | data_wr;
  assign rep_b_en = rep_v_d;
  assign tx_b_en  = ktx_v_d | atx_v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_INIT;
      stat_q    <= STAT_INIT;
      outp_q    <= OUTP_INIT;
      rep_b_q   <= '0;
      tx_b_q    <= '0;
      rst_req_q <= 1'b0;
      mupd_q    <= 1'b0;
      rep_v_q   <= 1'b0;
      rep_aux_q <= 1'b0;
      ktx_v_q   <= 1'b0;
      atx_v_q   <= 1'b0;
    end else begin
      if (state_en) begin
        mode_q <= mode_d;
        stat_q <= stat_d;
        outp_q <= outp_d;
      end
      if (rep_b_en) rep_b_q <= rep_b_d;
      if (tx_b_en)  tx_b_q  <= tx_b_d;
      rst_req_q <= rst_req_d;
      mupd_q    <= mupd_d;
      rep_v_q   <= rep_v_d;
      rep_aux_q <= rep_aux_d;
      ktx_v_q   <= ktx_v_d;
      atx_v_q   <= atx_v_d;
    end
  end

  // R4
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr && pend == PEND_MODE) |=> (mupd_q && mode_q == $past(wr_byte)));
  // R6
  selftest_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[STAT_SELFTEST_BIT]) |-> $past(cmd_wr && wr_byte == CMD_SELFTEST));
  // R8
  a20_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outp_q[OUTP_A20_BIT]) |-> $past(cmd_wr || data_wr));
  // R9
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> $past(cmd_wr || (data_wr && pend == PEND_OUTP)));
endmodule

// File: rtl/kbc_host_decoder.sv
module kbc_host_decoder
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_INIT = 8'h03,
  parameter logic [BYTE_W-1:0] STAT_INIT = 8'h18,
  parameter logic [BYTE_W-1:0] OUTP_INIT = 8'hCF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] status_byte,
  output logic [BYTE_W-1:0] mode_byte,
  output logic [BYTE_W-1:0] outport_byte,
  output logic              a20_gate,
  output logic              sys_reset_req,
  output logic              mode_upd,
  output logic              reply_valid,
  output logic              reply_aux,
  output logic [BYTE_W-1:0] reply_byte,
  output logic              kbd_tx_valid,
  output logic              aux_tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  cmd_dec_t dec;
  pend_e    pend;

  kbc_cmd_decode u_dec (.cmd(wr_byte), .dec(dec));

  kbc_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .dec(dec), .pend(pend)
  );

  kbc_regs #(.MODE_INIT(MODE_INIT), .STAT_INIT(STAT_INIT), .OUTP_INIT(OUTP_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wr_byte(wr_byte),
    .dec(dec), .pend(pend),
    .mode_q(mode_byte), .stat_q(status_byte), .outp_q(outport_byte),
    .rst_req_q(sys_reset_req), .mupd_q(mode_upd),
    .rep_v_q(reply_valid), .rep_aux_q(reply_aux), .rep_b_q(reply_byte),
    .ktx_v_q(kbd_tx_valid), .atx_v_q(aux_tx_valid), .tx_b_q(tx_byte)
  );

  assign a20_gate = outport_byte[OUTP_A20_BIT];

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reply_valid, kbd_tx_valid, aux_tx_valid, mode_upd}));
endmodule

// File: tb/kbc_host_decoder_test.sv
`timescale 1ns/1ps
module kbc_host_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] status_byte, mode_byte, outport_byte, reply_byte, tx_byte;
  logic       a20_gate, sys_reset_req, mode_upd, reply_valid, reply_aux;
  logic       kbd_tx_valid, aux_tx_valid;

  always #2 clk = ~clk;

  kbc_host_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wr_byte(wr_byte),
    .status_byte(status_byte), .mode_byte(mode_byte), .outport_byte(outport_byte),
    .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .mode_upd(mode_upd),
    .reply_valid(reply_valid), .reply_aux(reply_aux), .reply_byte(reply_byte),
    .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid), .tx_byte(tx_byte)
  );

  localparam int EV_KTX = 0, EV_ATX = 1, EV_REP = 2, EV_REPAUX = 3, EV_RST = 4, EV_MUPD = 5;

  typedef struct {
    int         kind;
    logic [7:0] b;
    string      tag;
  } ev_t;

  ev_t expq[$];
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [7:0] b, string tag);
    ev_t e;
    e.kind = kind; e.b = b; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic see_ev(int kind, logic [7:0] b);
    ev_t e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual kind %0d byte 0x%0h expected none", kind, b);
    end else begin
      e = expq.pop_front();
      if (e.kind != kind || e.b !== b) begin
        errors++;
        $display("FAIL %s: actual kind %0d byte 0x%0h expected kind %0d byte 0x%0h",
                 e.tag, kind, b, e.kind, e.b);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (kbd_tx_valid) see_ev(EV_KTX, tx_byte);
      if (aux_tx_valid) see_ev(EV_ATX, tx_byte);
      if (reply_valid)  see_ev(reply_aux ? EV_REPAUX : EV_REP, reply_byte);
      if (sys_reset_req) see_ev(EV_RST, 8'h00);
      if (mode_upd)     see_ev(EV_MUPD, 8'h00);
    end
  end

  task automatic do_cmd(logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; wr_byte = b;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic do_data(logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; wr_byte = b;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_byte, 8'h03);
    check("R1 status", status_byte, 8'h18);
    check("R1 outport", outport_byte, 8'hCF);
    check("R1 a20", a20_gate, 1'b1);
    check("R1 strobes", {sys_reset_req, mode_upd, reply_valid, kbd_tx_valid, aux_tx_valid}, 5'b0);
    // R2 / R1: nothing armed, data goes to keyboard
    expect_ev(EV_KTX, 8'h1C, "R2 kbd forward");
    do_data(8'h1C);
    // R5 canned and state replies
    expect_ev(EV_REP, 8'h03, "R5 read mode"); do_cmd(8'h20);
    expect_ev(EV_REP, 8'hCF, "R5 read outport"); do_cmd(8'hD0);
    expect_ev(EV_REP, 8'h80, "R5 read inport"); do_cmd(8'hC0);
    expect_ev(EV_REP, 8'h00, "R5 aux test"); do_cmd(8'hA9);
    expect_ev(EV_REP, 8'h00, "R5 kbd test"); do_cmd(8'hAB);
    // R6 self test
    expect_ev(EV_REP, 8'h55, "R6 self test reply"); do_cmd(8'hAA);
    check("R6 status bit2", status_byte, 8'h1C);
    // R7 interface disable bits
    do_cmd(8'hA7); check("R7 aux off", mode_byte, 8'h23);
    do_cmd(8'hA8); check("R7 aux on", mode_byte, 8'h03);
    do_cmd(8'hAD); check("R7 kbd off", mode_byte, 8'h13);
    do_cmd(8'hAE); check("R7 kbd on", mode_byte, 8'h03);
    // R8 A20 commands
    do_cmd(8'hDD); check("R8 outport low", outport_byte, 8'hCD); check("R8 a20 low", a20_gate, 1'b0);
    do_cmd(8'hDF); check("R8 outport high", outport_byte, 8'hCF); check("R8 a20 high", a20_gate, 1'b1);
    // R4 / R3 mode write then disarm
    do_cmd(8'h60);
    expect_ev(EV_MUPD, 8'h00, "R4 mode strobe");
    do_data(8'h45);
    check("R4 mode value", mode_byte, 8'h45);
    expect_ev(EV_KTX, 8'h77, "R3 disarmed after data");
    do_data(8'h77);
    // R11 output buffer writes
    do_cmd(8'hD2); expect_ev(EV_REP, 8'hAB, "R11 kbd obuf"); do_data(8'hAB);
    do_cmd(8'hD3); expect_ev(EV_REPAUX, 8'h5A, "R11 aux obuf"); do_data(8'h5A);
    // R12 send to mouse
    do_cmd(8'hD4); expect_ev(EV_ATX, 8'hF4, "R12 aux forward"); do_data(8'hF4);
    expect_ev(EV_KTX, 8'hD1, "R3 disarmed after aux send"); do_data(8'hD1);
    // R10 output port writes
    do_cmd(8'hD1); do_data(8'hDD);
    check("R10 outport value", outport_byte, 8'hDD); check("R10 a20 follows", a20_gate, 1'b0);
    do_cmd(8'hD1); expect_ev(EV_RST, 8'h00, "R10 reset via bit0"); do_data(8'hCE);
    check("R10 outport value2", outport_byte, 8'hCE); check("R10 a20 follows2", a20_gate, 1'b1);
    do_cmd(8'hD1); do_data(8'hCF);
    // R9 pulse range folding
    expect_ev(EV_RST, 8'h00, "R9 FE reset"); do_cmd(8'hFE);
    do_cmd(8'hFF);
    expect_ev(EV_RST, 8'h00, "R9 F0 reset"); do_cmd(8'hF0);
    do_cmd(8'hF3);
    do_cmd(8'hF1);
    check("R9 outport untouched", outport_byte, 8'hCF);
    // R13 unknown commands
    do_cmd(8'h12); do_cmd(8'hB5);
    check("R13 mode", mode_byte, 8'h45);
    check("R13 status", status_byte, 8'h1C);
    check("R13 outport", outport_byte, 8'hCF);
    repeat (3) @(negedge clk);
    check("R13 all expected events seen", expq.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule